// File: doc/BRIEF.md
# Cascadable Serial Input Front End for a 12-bit DAC

This block is the digital input stage of a 12-bit serial converter. While the active-low select `cs_n` is held low, each rising edge of the serial clock `sclk` shifts one bit from `din` into a 16-bit register, most significant bit first. The bits that leave the far end of that register are driven on `dout`, so the output of one device can feed the serial input of the next. Any number of devices can be chained this way.

When `cs_n` returns high, the twelve most recently received bits are copied into the code register. The first four bits of a 16-bit word act only as padding. The block presents the code as an unsigned value. It also presents a signed view for bipolar operation, where the code is offset binary and its top bit gives the polarity. An active-low asynchronous clear `clr_n` forces the code register to zero.

All serial pins are sampled by a faster system clock. Each one passes through a two-stage synchroniser before edge detection, so every serial event reaches the outputs three system clocks after the pin changes.

Top module: `sdac_front`

## Requirements
- R1: While synchronous `rst` is high, and right after it is released, `dout` is 0, the code is 0 and the shift register holds all zeros.
- R2: `din` is taken on a rising `sclk` edge only while `cs_n` is low, and enters at the least significant end so that the first bit sent ends up as the most significant bit. `sclk` edges while `cs_n` is high change nothing.
- R3: The bit stream on `dout` repeats the stream taken from `din`, delayed by 16 `sclk` periods plus half a period. The bit taken on rising edge k appears on the falling edge that follows rising edge k+16.
- R4: While `cs_n` is low, `dout` changes only as the result of a falling `sclk` edge.
- R5: While `cs_n` is high, `dout` keeps driving the last bit it shifted out.
- R6: On a rising edge of `cs_n`, the code register loads the 12 most recently received bits. The most recent bit becomes code bit 0, and the four bits received before those twelve are ignored.
- R7: If a frame has fewer or more than 16 clocks, the code register takes whatever the 12 low bits of the shift register hold at the rising edge of `cs_n`.
- R8: While `clr_n` is low, the code register is 0, with no wait for a clock. The shift register contents and `dout` are not disturbed.
- R9: `dac_signed` is the code minus 2048, read as a 12-bit two's-complement value. Code 0 gives -2048, code 0x800 gives 0 and code 0xFFF gives +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; idles low |
| cs_n | input | 1 | Active-low select that frames a word |
| din | input | 1 | Serial data in, MSB first |
| clr_n | input | 1 | Asynchronous active-low clear of the code register |
| dout | output | 1 | Serial data out for cascading; always driven |
| dac_code | output | 12 | Unsigned converter code |
| dac_signed | output | 12 | Two's-complement bipolar view of the code |

## Verification
The assertions assume that `sclk` and `cs_n` stay at each level for several system clocks. They also assume that an `sclk` edge never reaches the synchroniser output in the same cycle as a `cs_n` edge, and that `clr_n` stays low across at least one `clk` edge. The stimulus holds each serial level for four system clocks. It idles `sclk` low around every change of `cs_n`, and it drives every pin one nanosecond after a `clk` rising edge. It also exercises short frames, long frames, a 32-bit cascade frame and clock edges sent while the device is deselected.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int WORD_W      = 16;
    localparam int CODE_W      = 12;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic din;
    } pins_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic load;
    } events_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0};
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int STAGES = sdac_pkg::SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  sdac_pkg::pins_t d,
    output sdac_pkg::pins_t q
);
    sdac_pkg::pins_t pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= sdac_pkg::PINS_IDLE;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int WORD_W = sdac_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sdac_pkg::events_t ev,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              dout
);
    logic tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            tail <= 1'b0;
            dout <= 1'b0;
        end else begin
            if (ev.rise) begin
                word <= {word[WORD_W-2:0], din};
                tail <= word[WORD_W-1];
            end
            if (ev.fall) dout <= tail;
        end
    end
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
    parameter int WORD_W = sdac_pkg::WORD_W,
    parameter int CODE_W = sdac_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    code <= '0;
        else if (rst)  code <= '0;
        else if (load) code <= word[CODE_W-1:0];
    end
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
    parameter int WORD_W      = sdac_pkg::WORD_W,
    parameter int CODE_W      = sdac_pkg::CODE_W,
    parameter int SYNC_STAGES = sdac_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              clr_n,
    output logic              dout,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] dac_signed
);
    sdac_pkg::pins_t   raw_pins, now_pins, prev_pins;
    sdac_pkg::events_t ev;
    logic [WORD_W-1:0] shift_word;
    logic sclk_rise, sclk_fall, cs_rise, cs_level, din_level;

    assign raw_pins = '{sclk: sclk, cs_n: cs_n, din: din};

    sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (now_pins)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_pins <= sdac_pkg::PINS_IDLE;
        else     prev_pins <= now_pins;
    end

    assign cs_level  = now_pins.cs_n;
    assign din_level = now_pins.din;
    assign sclk_rise = now_pins.sclk & ~prev_pins.sclk & ~now_pins.cs_n;
    assign sclk_fall = ~now_pins.sclk & prev_pins.sclk & ~now_pins.cs_n;
    assign cs_rise   = now_pins.cs_n & ~prev_pins.cs_n;
    assign ev        = '{rise: sclk_rise, fall: sclk_fall, load: cs_rise};

    sdac_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .din  (din_level),
        .word (shift_word),
        .dout (dout)
    );

    sdac_latch #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .load  (ev.load),
        .word  (shift_word),
        .code  (dac_code)
    );

    assign dac_signed = {~dac_code[CODE_W-1], dac_code[CODE_W-2:0]};
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int WORD_W = sdac_pkg::WORD_W,
    parameter int CODE_W = sdac_pkg::CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              cs_rise,
    input logic              cs_level,
    input logic              din_level,
    input logic [WORD_W-1:0] shift_word,
    input logic              dout,
    input logic [CODE_W-1:0] dac_code
);
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> shift_word[0] == $past(din_level));

    assert_dout_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> $past(sclk_fall));

    assert_hold_deselected_R5: assert property (@(posedge clk) disable iff (rst)
        cs_level |=> $stable(dout));

    assert_load_code_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && clr_n) |=> (!clr_n || dac_code == $past(shift_word[CODE_W-1:0])));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> dac_code == '0);
endmodule

bind sdac_front sdac_front_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_n      (clr_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_rise    (cs_rise),
    .cs_level   (cs_level),
    .din_level  (din_level),
    .shift_word (shift_word),
    .dout       (dout),
    .dac_code   (dac_code)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_r = 1'b0, cs_r = 1'b1, din_r = 1'b0, clr_r = 1'b1;
    logic dout;
    logic [11:0] dac_code, dac_signed;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    sdac_front u0 (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk_r),
        .cs_n       (cs_r),
        .din        (din_r),
        .clr_n      (clr_r),
        .dout       (dout),
        .dac_code   (dac_code),
        .dac_signed (dac_signed)
    );

    // Behavioural reference: pin history delayed by the sampling latency, a bit queue.
    logic h1_s, h1_c, h1_d, h2_s, h2_c, h2_d, hp_s, hp_c;
    bit   rxq[$];
    logic m_dout;
    int   m_code;

    task automatic model_reset();
        h1_s = 0; h1_c = 1; h1_d = 0;
        h2_s = 0; h2_c = 1; h2_d = 0;
        hp_s = 0; hp_c = 1;
        rxq.delete();
        for (int i = 0; i < 17; i++) rxq.push_back(1'b0);
        m_dout = 0;
        m_code = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            if (!h2_c && h2_s && !hp_s) begin
                rxq.push_back(h2_d);
                if (rxq.size() > 40) void'(rxq.pop_front());
            end
            if (!h2_c && !h2_s && hp_s) m_dout = rxq[rxq.size()-17];
            if (h2_c && !hp_c) begin
                m_code = 0;
                for (int i = 12; i >= 1; i--) m_code = m_code * 2 + int'(rxq[rxq.size()-i]);
            end
            if (!clr_r) m_code = 0;
            hp_s = h2_s; hp_c = h2_c;
            h2_s = h1_s; h2_c = h1_c; h2_d = h1_d;
            h1_s = sclk_r; h1_c = cs_r; h1_d = din_r;
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!clr_r) m_code = 0;
            check("R3 dout", int'(dout), int'(m_dout));
            check("R6 code", int'(dac_code), m_code);
            check("R9 signed", int'($signed(dac_signed)), m_code - 2048);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(logic [63:0] v, int n);
        cs_r = 0;
        tick(H);
        for (int i = n - 1; i >= 0; i--) begin
            din_r = v[i];
            tick(H);
            sclk_r = 1;
            tick(H);
            sclk_r = 0;
        end
        tick(H);
        cs_r = 1;
        tick(2 * H);
    endtask

    task automatic expect_out(string req, int code);
        @(negedge clk);
        check(req, int'(dac_code), code);
        check(req, int'($signed(dac_signed)), code - 2048);
    endtask

    initial begin
        logic saved;
        tick(4);
        rst = 0;
        tick(2);
        @(negedge clk);
        check("R1 dout", int'(dout), 0);
        expect_out("R1 code", 0);

        send(64'hA5C3, 16);
        expect_out("R6 top four ignored", 'h5C3);

        saved = dout;
        din_r = 1;
        for (int k = 0; k < 5; k++) begin
            sclk_r = 1; tick(H); sclk_r = 0; tick(H);
        end
        @(negedge clk);
        check("R5 dout held deselected", int'(dout), int'(saved));
        send(64'h6, 4);
        expect_out("R2 clocks ignored while deselected", 'hC36);

        send(64'h0FFF, 16);
        expect_out("R9 full scale", 'hFFF);
        send(64'h1000, 16);
        expect_out("R9 zero code", 0);
        send(64'h3800, 16);
        expect_out("R9 midscale", 'h800);

        send(64'hABCDE, 20);
        expect_out("R7 long frame", 'hCDE);

        saved = dout;
        tick(3);
        clr_r = 0;
        tick(1);
        @(negedge clk);
        check("R8 clear code", int'(dac_code), 0);
        check("R8 dout untouched", int'(dout), int'(saved));
        tick(3);
        clr_r = 1;
        tick(2);
        send(64'h9, 4);
        expect_out("R8 shift intact", 'hDE9);

        send(64'h0001_0ABC, 32);
        expect_out("R6 cascade frame", 'hABC);
        check("R3 cascade bit out", int'(dout), 1);

        send(64'h0000, 16);
        @(negedge clk);
        check("R3 stream", int'(dout), 0);

        rst = 1;
        tick(3);
        @(negedge clk);
        check("R1 reset dout", int'(dout), 0);
        check("R1 reset code", int'(dac_code), 0);
        rst = 0;
        tick(2);
        send(64'h0, 4);
        expect_out("R1 shift cleared", 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 150000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule